// File: doc/BRIEF.md
# Dual Output Overlap Delay Generator

This block turns one internal drive request into two in-phase gate controls. The main output switches the primary power device. The secondary output drives a synchronous rectifier, and it brackets the main pulse on both edges. When the request rises, the secondary output turns on first and the main output follows after a programmable leading delay. When the request falls, the main output turns off first and the secondary output follows after a programmable trailing delay. Both delays are counted in clock cycles.

A fault input drops both outputs together in a single cycle and skips the delay sequence. The delay settings are taken only while both outputs are low, so a setting that changes mid-pulse cannot corrupt the pulse in progress. The block also checks each delay setting against the off interval that came before it. It raises a warning when a delay needs more than half of that interval, because that much delay leaves no valid dead time.

Top module: `dual_gate_sequencer`

## Requirements
- R1: After reset `main_o`, `sync_o` and `dly_warn_o` are all 0.
- R2: When the first clock edge samples `pwm_req_i` high from the idle state, `sync_o` rises at that edge. For a leading delay L>0, `main_o` rises L edges later, and `main_o` is never high while `sync_o` is low.
- R3: At the first edge that samples `pwm_req_i` low while `main_o` is high, `main_o` falls at that edge. `sync_o` falls T edges later, where T is the trailing delay.
- R4: A leading delay of 0 makes both outputs rise at the same edge. A trailing delay of 0 makes both outputs fall at the same edge.
- R5: At any edge that samples `force_off_i` high, both outputs go low at that edge. They stay low while it remains high. After it is released with the request high, a fresh leading sequence starts.
- R6: A request held high keeps both outputs high without a break.
- R7: If the request falls before the leading delay expires, `main_o` never rises, and `sync_o` falls T edges after the edge that sampled the request low.
- R8: If the request rises again during the trailing delay, `sync_o` stays high, and `main_o` rises L edges after the edge that sampled the new rise.
- R9: `lead_dly_i` and `trail_dly_i` are sampled only at edges where both outputs are low. A change while either output is high has no effect on that pulse.
- R10: At each edge that samples a request rise, `dly_warn_o` is set if twice the leading delay or twice the trailing delay exceeds the number of edges the request was low just before, and cleared otherwise. At every other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_req_i | input | 1 | Drive request from the modulator |
| force_off_i | input | 1 | Fault: drop both outputs with no delay |
| lead_dly_i | input | DLY_W | Leading delay in cycles (secondary-on to main-on) |
| trail_dly_i | input | DLY_W | Trailing delay in cycles (main-off to secondary-off) |
| main_o | output | 1 | Main switch control |
| sync_o | output | 1 | Synchronous rectifier control |
| dly_warn_o | output | 1 | Delay setting exceeds half of the preceding off interval |

## Verification
Edge changes are due at fixed cycle offsets from the edge that samples a stimulus:
- `sync_o` rising, `main_o` falling, forced drops and the warning update are all due at that same edge.
- `main_o` rises L edges later.
- `sync_o` falls T edges later.

A driver task applies inputs on the falling clock edge and pushes the expected output triple for the next rising edge into a queue. The monitor pops one entry 2 ns after every rising edge, so each comparison lands exactly on the cycle in which a registered result becomes visible. Scenarios cover cancellation, re-triggering and forced drops at every phase of the sequence.

// File: rtl/gds_pkg.sv
package gds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_ON    = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/gds_delay_counter.sv
module gds_delay_counter #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic             last_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // final counted cycle of a loaded delay
  assign last_o = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/gds_phase_fsm.sv
module gds_phase_fsm
  import gds_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             force_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [DLY_W-1:0] load_val_o,
  output seq_state_e       state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (force_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (lead_i == '0) begin
              state_d = ST_ON;
            end else begin
              state_d    = ST_LEAD;
              load_o     = 1'b1;
              load_val_o = lead_i;
            end
          end
        end
        ST_LEAD, ST_ON: begin
          if (!req_i) begin
            // cancel or normal release both go through trailing delay
            if (trail_i == '0) begin
              state_d = ST_IDLE;
            end else begin
              state_d    = ST_TRAIL;
              load_o     = 1'b1;
              load_val_o = trail_i;
            end
          end else if (state_q == ST_LEAD && last_i) begin
            state_d = ST_ON;
          end
        end
        ST_TRAIL: begin
          if (req_i) begin
            if (lead_i == '0) begin
              state_d = ST_ON;
            end else begin
              state_d    = ST_LEAD;
              load_o     = 1'b1;
              load_val_o = lead_i;
            end
          end else if (last_i) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/gds_offtime_monitor.sv
module gds_offtime_monitor #(
  parameter int DLY_W = 8,
  parameter int OFF_W = DLY_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  output logic             warn_o
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [OFF_W-1:0] off_cnt_q;
  logic [OFF_W-1:0] lead_x2, trail_x2;
  logic             too_long;

  assign lead_x2  = OFF_W'({lead_i, 1'b0});
  assign trail_x2 = OFF_W'({trail_i, 1'b0});
  assign too_long = (lead_x2 > off_cnt_q) || (trail_x2 > off_cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt_q <= '0;
      warn_o    <= 1'b0;
    end else if (!req_i) begin
      if (off_cnt_q != OFF_MAX) off_cnt_q <= off_cnt_q + 1'b1;
    end else begin
      // nonzero count marks the first high sample after an off interval
      if (off_cnt_q != '0) warn_o <= too_long;
      off_cnt_q <= '0;
    end
  end
endmodule

// File: rtl/dual_gate_sequencer.sv
module dual_gate_sequencer
  import gds_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_req_i,
  input  logic             force_off_i,
  input  logic [DLY_W-1:0] lead_dly_i,
  input  logic [DLY_W-1:0] trail_dly_i,
  output logic             main_o,
  output logic             sync_o,
  output logic             dly_warn_o
);
  localparam int OFF_W = DLY_W + 2;

  seq_state_e       state;
  logic [DLY_W-1:0] lead_q, trail_q;
  logic [DLY_W-1:0] lead_eff, trail_eff;
  logic             cnt_load, cnt_last;
  logic [DLY_W-1:0] cnt_val;
  logic             idle;

  assign idle = (state == ST_IDLE);

  // settings follow the pins only while both outputs are low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_q  <= '0;
      trail_q <= '0;
    end else if (idle) begin
      lead_q  <= lead_dly_i;
      trail_q <= trail_dly_i;
    end
  end

  assign lead_eff  = idle ? lead_dly_i  : lead_q;
  assign trail_eff = idle ? trail_dly_i : trail_q;

  gds_phase_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (pwm_req_i),
    .force_i    (force_off_i),
    .lead_i     (lead_eff),
    .trail_i    (trail_eff),
    .last_i     (cnt_last),
    .load_o     (cnt_load),
    .load_val_o (cnt_val),
    .state_o    (state)
  );

  gds_delay_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .last_o     (cnt_last)
  );

  gds_offtime_monitor #(.DLY_W(DLY_W), .OFF_W(OFF_W)) u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (pwm_req_i),
    .lead_i  (lead_eff),
    .trail_i (trail_eff),
    .warn_o  (dly_warn_o)
  );

  assign sync_o = !idle;
  assign main_o = (state == ST_ON);
endmodule

// File: rtl/dual_gate_sequencer_sva.sv
module dual_gate_sequencer_sva #(
  parameter int DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_req_i,
  input logic             force_off_i,
  input logic [DLY_W-1:0] lead_dly_i,
  input logic             main_o,
  input logic             sync_o,
  input logic             dly_warn_o
);
  assert_main_within_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_o |-> sync_o);

  assert_sync_rise_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(pwm_req_i));

  assert_lead_holds_main_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && $past(lead_dly_i) != '0) |-> !main_o);

  assert_req_low_drops_main_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_req_i |=> !main_o);

  assert_zero_lead_coincident_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_o) && $past(lead_dly_i) == '0) |-> main_o);

  assert_force_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!main_o && !sync_o));

  assert_steady_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_o && pwm_req_i && !force_off_i) |=> main_o);

  assert_retrigger_keeps_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && pwm_req_i && !force_off_i) |=> sync_o);

  assert_warn_only_on_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dly_warn_o) |-> $past(pwm_req_i));
endmodule

bind dual_gate_sequencer dual_gate_sequencer_sva #(.DLY_W(DLY_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_req_i   (pwm_req_i),
  .force_off_i (force_off_i),
  .lead_dly_i  (lead_dly_i),
  .main_o      (main_o),
  .sync_o      (sync_o),
  .dly_warn_o  (dly_warn_o)
);

// File: tb/dual_gate_sequencer_tb.sv
module dual_gate_sequencer_tb;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pwm_req = 1'b0;
  logic             force_off = 1'b0;
  logic [DLY_W-1:0] lead_dly = '0;
  logic [DLY_W-1:0] trail_dly = '0;
  logic             main_o, sync_o, dly_warn_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_gate_sequencer #(.DLY_W(DLY_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pwm_req_i   (pwm_req),
    .force_off_i (force_off),
    .lead_dly_i  (lead_dly),
    .trail_dly_i (trail_dly),
    .main_o      (main_o),
    .sync_o      (sync_o),
    .dly_warn_o  (dly_warn_o)
  );

  typedef struct {
    bit    e_main;
    bit    e_sync;
    bit    e_warn;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // requirement model state
  int lead_nxt = 0, trail_nxt = 0;
  int m_lead = 0, m_trail = 0;
  bit prev_sync = 0, prev_req = 0, m_warn = 0;
  int hi_i = 0, lo_j = 1000, off_len = 0;

  task automatic set_dly(input int l, input int t);
    lead_nxt  = l;
    trail_nxt = t;
  endtask

  task automatic step(input bit req, input bit frc, input string tag);
    exp_t e;
    @(negedge clk);
    pwm_req   = req;
    force_off = frc;
    lead_dly  = DLY_W'(lead_nxt);
    trail_dly = DLY_W'(trail_nxt);
    if (!prev_sync) begin
      m_lead  = lead_nxt;
      m_trail = trail_nxt;
    end
    if (!req) begin
      if (off_len < 1023) off_len++;
    end else begin
      if (off_len > 0) m_warn = (2 * m_lead > off_len) || (2 * m_trail > off_len);
      off_len = 0;
    end
    if (frc) begin
      e.e_main = 0; e.e_sync = 0;
      prev_req = 0; lo_j = 1000;
    end else if (req) begin
      if (!prev_req) hi_i = 0; else hi_i++;
      e.e_sync = 1; e.e_main = (hi_i >= m_lead);
      prev_req = 1;
    end else begin
      if (prev_req) lo_j = 0; else if (lo_j < 1000) lo_j++;
      e.e_main = 0; e.e_sync = (lo_j < m_trail);
      prev_req = 0;
    end
    e.e_warn = m_warn;
    e.tag = tag;
    prev_sync = e.e_sync;
    exp_q.push_back(e);
  endtask

  task automatic pulse(input int hi, input int lo, input string tag);
    for (int i = 0; i < hi; i++) step(1'b1, 1'b0, tag);
    for (int j = 0; j < lo; j++) step(1'b0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (main_o !== e.e_main || sync_o !== e.e_sync || dly_warn_o !== e.e_warn) begin
          failures++;
          $display("FAIL %s: actual main=%b sync=%b warn=%b expected main=%b sync=%b warn=%b",
                   e.tag, main_o, sync_o, dly_warn_o, e.e_main, e.e_sync, e.e_warn);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R0 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (main_o !== 1'b0 || sync_o !== 1'b0 || dly_warn_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual main=%b sync=%b warn=%b expected 0 0 0",
               main_o, sync_o, dly_warn_o);
    end
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, "R1 idle after reset");

    set_dly(3, 2);  pulse(8, 6, "R2/R3 lead3 trail2");
    set_dly(0, 0);  pulse(4, 4, "R4 zero delays");
    set_dly(5, 1);  pulse(9, 5, "R3 asymmetric lead5 trail1");
    set_dly(6, 3);  pulse(3, 8, "R7 cancel during lead");
    set_dly(2, 5);  pulse(6, 2, "R8 re-rise in trail");
    pulse(6, 8, "R8 second pulse");

    set_dly(2, 4);  pulse(3, 0, "R9 start");
    set_dly(9, 0);  pulse(3, 8, "R9 change ignored while busy");
    pulse(12, 4, "R9 new values after idle");

    set_dly(2, 3);  pulse(5, 0, "R5 on");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, "R5 force while on");
    pulse(5, 1, "R5 restart after release");
    for (int k = 0; k < 2; k++) step(1'b0, 1'b1, "R5 force during trail");
    pulse(0, 5, "R5 idle after force");
    set_dly(2, 0);  pulse(1, 0, "R5 lead");
    step(1'b1, 1'b1, "R5 force during lead");
    pulse(0, 20, "R5 idle");

    set_dly(1, 1);  pulse(60, 20, "R6 continuous request");

    set_dly(10, 2); pulse(14, 8, "R10 short off");
    pulse(14, 30, "R10 warn set");
    pulse(14, 4, "R10 warn cleared");
    set_dly(1, 12); pulse(3, 20, "R10 trail vs off");
    pulse(3, 30, "R10 trail warn");
    pulse(3, 4, "R10 trail warn cleared");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule